// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It does so by reading a two-level page table that sits in ordinary memory. A requester presents one translation request at a time. The request carries the virtual address, the access kind (read, write or execute) and the physical base address of the page directory. The walker then issues word reads on a simple memory port. The first read fetches the directory entry and the second fetches the table entry. When the walk ends, the walker returns either the physical address or a fault code, together with a one-cycle completion pulse.

The virtual address is split into three fields: a 10-bit directory index, a 10-bit table index and a 12-bit page offset. A write through a table entry whose dirty flag is clear gets one extra cycle of work. In that case the walker stores the entry back to memory with the dirty flag set before it reports the result. Caching of translations, backing-store paging and fault recovery are handled outside this block.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1, while `done` and `mem_req_valid` are both 0.
- R2: The first read of a walk targets `ptbr + 4*vaddr[31:22]`. The value of `ptbr` is taken when the request is accepted.
- R3: The second read targets `{pde[31:12], 12'h000} + 4*vaddr[21:12]`.
- R4: A successful walk returns `{pte[31:12], vaddr[11:0]}` with `done_fault` = 0. Whenever `done_fault` is non-zero, `done_paddr` is 0.
- R5: If bit 0 (present) of the directory entry is 0, the walk ends after that single read with `done_fault` = 1 (not present).
- R6: If bit 0 of the table entry is 0, the walk ends with `done_fault` = 1.
- R7: `req_kind` is encoded as 0 = read, 1 = write, 2 = execute and 3 = reserved. Kinds 0, 1 and 2 need bits 1, 2 and 3 of the table entry respectively. A kind whose bit is 0, and the reserved kind, end the walk with `done_fault` = 2 (protection).
- R8: A permitted write through a table entry whose bit 4 (dirty) is 0 issues exactly one memory write. The write goes to the table entry's address, and its data is the entry with bit 4 set.
- R9: A permitted write through an entry whose dirty bit is already set, and every read or execute walk, issue no memory write.
- R10: `done` is high for exactly one cycle per walk, and `req_ready` stays 0 from acceptance until after that cycle.
- R11: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request, its address and its write flag hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| ptbr | input | 32 | Physical base address of the page directory |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_we | output | 1 | 1 for the dirty write-back, 0 for entry reads |
| mem_req_addr | output | 32 | Physical word address of the entry |
| mem_req_wdata | output | 32 | Entry data for the write-back |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| done_paddr | output | 32 | Translated physical address (0 on fault) |
| done_fault | output | 2 | 0 none, 1 not present, 2 protection |

## Verification
The same virtual page is walked with read, execute, write and the reserved kind. This separates a permission check on the right entry bit from one on the wrong bit. The first write through a clean entry is followed by a second write through the same entry: the first must update memory and the second must leave it alone. A page that allows only execute is tried with every kind, so each permission bit is shown to gate its own kind and no other. Missing directory and table entries are told apart by how many reads the walk makes. Memory stalls and read latencies change from one vector to the next, which exposes any dependence on handshake timing. A change of the directory base register is checked by the address of the first read.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
   localparam int V_BIT = 0;
   localparam int R_BIT = 1;
   localparam int W_BIT = 2;
   localparam int X_BIT = 3;
   localparam int D_BIT = 4;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_ABSENT = 2'd1,
      FLT_PROT   = 2'd2
   } fault_e;

   typedef enum logic [2:0] {
      S_IDLE, S_PDE_REQ, S_PDE_WAIT, S_PTE_REQ, S_PTE_WAIT, S_WB_REQ, S_DONE
   } walk_st_e;
endpackage

// File: rtl/pgwalk_split.sv
module pgwalk_split #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 10,
   parameter int OFF_W  = 12
) (
   input  logic [ADDR_W-1:0]       vaddr,
   input  logic [ADDR_W-1:0]       ptbr,
   input  logic [ADDR_W-OFF_W-1:0] pde_ppn,
   output logic [ADDR_W-1:0]       pde_addr,
   output logic [ADDR_W-1:0]       pte_addr,
   output logic [OFF_W-1:0]        page_off
);
   localparam int PAD_W = ADDR_W - IDX_W - 2;

   logic [IDX_W-1:0] dir_idx;
   logic [IDX_W-1:0] tbl_idx;

   assign dir_idx  = vaddr[ADDR_W-1 -: IDX_W];
   assign tbl_idx  = vaddr[OFF_W +: IDX_W];
   assign page_off = vaddr[OFF_W-1:0];

   assign pde_addr = ptbr + {{PAD_W{1'b0}}, dir_idx, 2'b00};
   assign pte_addr = {pde_ppn, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, tbl_idx, 2'b00};
endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
   import pgwalk_pkg::*;
#(
   parameter int ENT_W = 32
) (
   input  logic [ENT_W-1:0] entry,
   input  logic [1:0]       kind,
   output logic             allowed,
   output logic             mark,
   output logic [ENT_W-1:0] marked
);
   localparam int NKIND = 3;
   localparam int POS [NKIND] = '{R_BIT, W_BIT, X_BIT};

   logic [NKIND-1:0] grant;

   for (genvar k = 0; k < NKIND; k++) begin : g_grant
      assign grant[k] = (kind == 2'(k)) && entry[POS[k]];
   end

   assign allowed = |grant;
   assign mark    = grant[ACC_WRITE] && !entry[D_BIT];
   assign marked  = entry | (ENT_W'(1) << D_BIT);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
   import pgwalk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 10,
   parameter int OFF_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] ptbr,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [ADDR_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [ADDR_W-1:0] mem_rsp_rdata,
   output logic              done,
   output logic [ADDR_W-1:0] done_paddr,
   output logic [1:0]        done_fault
);
   localparam int PPN_W = ADDR_W - OFF_W;

   if (ADDR_W != 2*IDX_W + OFF_W) begin : g_bad_split
      $error("address split does not cover the address width");
   end
   if (OFF_W != IDX_W + 2) begin : g_bad_entry
      $error("a table must fill exactly one page of 4-byte entries");
   end
   if (D_BIT >= OFF_W) begin : g_bad_flags
      $error("entry flags must sit below the page number");
   end

   walk_st_e          st;
   acc_e              kind_q;
   logic [ADDR_W-1:0] va_q, base_q, pte_q, paddr_q;
   logic [PPN_W-1:0]  pde_ppn_q;
   fault_e            fault_q;

   logic [ADDR_W-1:0] pde_addr, pte_addr, marked;
   logic [OFF_W-1:0]  page_off;
   logic              allowed, mark, hs;

   pgwalk_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
      .vaddr(va_q), .ptbr(base_q), .pde_ppn(pde_ppn_q),
      .pde_addr(pde_addr), .pte_addr(pte_addr), .page_off(page_off)
   );

   pgwalk_perm #(.ENT_W(ADDR_W)) u_perm (
      .entry(mem_rsp_rdata), .kind(kind_q),
      .allowed(allowed), .mark(mark), .marked(marked)
   );

   assign req_ready     = (st == S_IDLE);
   assign mem_req_valid = (st == S_PDE_REQ) || (st == S_PTE_REQ) || (st == S_WB_REQ);
   assign mem_req_we    = (st == S_WB_REQ);
   assign mem_req_addr  = (st == S_PDE_REQ) ? pde_addr : pte_addr;
   assign mem_req_wdata = pte_q;
   assign hs            = mem_req_valid && mem_req_ready;
   assign done          = (st == S_DONE);
   assign done_paddr    = paddr_q;
   assign done_fault    = fault_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         kind_q    <= ACC_READ;
         va_q      <= '0;
         base_q    <= '0;
         pte_q     <= '0;
         pde_ppn_q <= '0;
         paddr_q   <= '0;
         fault_q   <= FLT_NONE;
      end else begin
         case (st)
            S_IDLE: if (req_valid) begin
               va_q    <= req_vaddr;
               kind_q  <= acc_e'(req_kind);
               base_q  <= ptbr;
               paddr_q <= '0;
               fault_q <= FLT_NONE;
               st      <= S_PDE_REQ;
            end
            S_PDE_REQ: if (hs) st <= S_PDE_WAIT;
            S_PDE_WAIT: if (mem_rsp_valid) begin
               pde_ppn_q <= mem_rsp_rdata[ADDR_W-1:OFF_W];
               if (!mem_rsp_rdata[V_BIT]) begin
                  fault_q <= FLT_ABSENT;
                  st      <= S_DONE;
               end else begin
                  st <= S_PTE_REQ;
               end
            end
            S_PTE_REQ: if (hs) st <= S_PTE_WAIT;
            S_PTE_WAIT: if (mem_rsp_valid) begin
               pte_q <= marked;
               if (!mem_rsp_rdata[V_BIT]) begin
                  fault_q <= FLT_ABSENT;
                  st      <= S_DONE;
               end else if (!allowed) begin
                  fault_q <= FLT_PROT;
                  st      <= S_DONE;
               end else begin
                  paddr_q <= {mem_rsp_rdata[ADDR_W-1:OFF_W], page_off};
                  st      <= mark ? S_WB_REQ : S_DONE;
               end
            end
            S_WB_REQ: if (hs) st <= S_DONE;
            default: st <= S_IDLE;
         endcase
      end
   end

   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=>
         mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_busy_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_ready);

   p_fault_no_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done && (done_fault != 2'd0) |-> done_paddr == '0);

   p_wb_sets_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_we |-> mem_req_wdata[D_BIT] && mem_req_wdata[V_BIT]);

   p_wb_only_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_we |-> kind_q == ACC_WRITE);

   p_wb_then_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_we && mem_req_ready |=> done && !mem_req_valid);
endmodule

// File: tb/pgwalk_top_bench.sv
module pgwalk_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic [31:0] ptbr = 32'h1000_5000;
   logic        mem_req_valid, mem_req_we;
   logic        mem_req_ready = 1'b1;
   logic [31:0] mem_req_addr, mem_req_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_rdata = '0;
   logic        done;
   logic [31:0] done_paddr;
   logic [1:0]  done_fault;

   always #10 clk = ~clk;

   pgwalk_top u_pgwalk_top (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_kind(req_kind), .ptbr(ptbr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata),
      .done(done), .done_paddr(done_paddr), .done_fault(done_fault)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model
   logic [31:0] mem [logic [31:0]];
   bit          pend = 1'b0;
   logic [31:0] pend_addr = '0;
   int          wait_cnt = 0;
   int          lat_cfg = 0;
   int          stall_cfg = 0;
   int          cyc = 0;
   int          rd_n = 0;
   int          wr_n = 0;
   logic [31:0] rd_a0 = '0, rd_a1 = '0, wr_a = '0, wr_d = '0;

   function automatic logic [31:0] mrd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (mem_rsp_valid) pend = 1'b0;
      if (mem_req_valid && mem_req_ready) begin
         if (mem_req_we) begin
            mem[mem_req_addr] = mem_req_wdata;
            wr_a = mem_req_addr;
            wr_d = mem_req_wdata;
            wr_n++;
         end else begin
            pend      = 1'b1;
            pend_addr = mem_req_addr;
            wait_cnt  = lat_cfg;
            if (rd_n == 0) rd_a0 = mem_req_addr;
            else if (rd_n == 1) rd_a1 = mem_req_addr;
            rd_n++;
         end
      end
   end

   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      if (pend) begin
         if (wait_cnt == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_rdata = mrd(pend_addr);
         end else begin
            wait_cnt--;
         end
      end
      mem_req_ready = (stall_cfg == 0) || (cyc % 3 == 0);
   end

   task automatic walk(input logic [31:0] va, input logic [1:0] k,
                       output logic [1:0] f, output logic [31:0] pa, output bit hs_ok);
      int n = 0;
      rd_n = 0;
      wr_n = 0;
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = va;
      req_kind  = k;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done && n < 500) begin
         @(negedge clk);
         n++;
      end
      hs_ok = (n < 500) && !req_ready;
      f  = done_fault;
      pa = done_paddr;
      @(negedge clk);
      hs_ok = hs_ok && !done && req_ready;
   endtask

   // vectors: vaddr, kind, fault, paddr, dir entry addr, table entry addr, reads, writes, written word
   localparam int NV = 11;
   localparam logic [31:0] VA [NV] = '{32'h7192a44c, 32'h7192a44c, 32'h7192a44c, 32'h7192a44c,
      32'h7192b123, 32'h7192b123, 32'h7192b123, 32'h7192c010, 32'h00000abc, 32'h7192d888, 32'h7192a44c};
   localparam logic [1:0]  KD [NV] = '{2'd0, 2'd2, 2'd1, 2'd1, 2'd2, 2'd0, 2'd1, 2'd0, 2'd0, 2'd1, 2'd3};
   localparam logic [1:0]  FT [NV] = '{2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'd2, 2'd2, 2'd1, 2'd1, 2'd0, 2'd2};
   localparam logic [31:0] PA [NV] = '{32'h1481744c, 32'h0, 32'h1481744c, 32'h1481744c,
      32'h2abcd123, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000a888, 32'h0};
   localparam logic [31:0] PDEA [NV] = '{32'h10005718, 32'h10005718, 32'h10005718, 32'h10005718,
      32'h10005718, 32'h10005718, 32'h10005718, 32'h10005718, 32'h10005000, 32'h10005718, 32'h10005718};
   localparam logic [31:0] PTEA [NV] = '{32'h123454a8, 32'h123454a8, 32'h123454a8, 32'h123454a8,
      32'h123454ac, 32'h123454ac, 32'h123454ac, 32'h123454b0, 32'h0, 32'h123454b4, 32'h123454a8};
   localparam int NRD [NV] = '{2, 2, 2, 2, 2, 2, 2, 2, 1, 2, 2};
   localparam int NWR [NV] = '{0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0};
   localparam logic [31:0] WD [NV] = '{32'h0, 32'h0, 32'h14817017, 32'h0, 32'h0, 32'h0,
      32'h0, 32'h0, 32'h0, 32'h0, 32'h0};

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [1:0]  f;
      logic [31:0] pa;
      bit          hs_ok;

      mem[32'h10005718] = 32'h12345001;
      mem[32'h123454a8] = 32'h14817007;
      mem[32'h123454ac] = 32'h2abcd019;
      mem[32'h123454b4] = 32'h0000a017;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'h1);
      chk(done == 1'b0, "R1 done", 32'(done), 32'h0);
      chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 32'(mem_req_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         lat_cfg   = i % 4;
         stall_cfg = i % 2;
         walk(VA[i], KD[i], f, pa, hs_ok);
         // R4 R5 R6 R7: result and fault code
         chk(f == FT[i], $sformatf("R4/R5/R6/R7 fault v%0d", i), 32'(f), 32'(FT[i]));
         chk(pa == PA[i], $sformatf("R4 paddr v%0d", i), pa, PA[i]);
         // R10: pulse and ready behaviour
         chk(hs_ok, $sformatf("R10 done pulse v%0d", i), 32'(hs_ok), 32'h1);
         // R2: directory entry address
         chk(rd_a0 == PDEA[i], $sformatf("R2 dir addr v%0d", i), rd_a0, PDEA[i]);
         // R5: number of reads
         chk(rd_n == NRD[i], $sformatf("R5 read count v%0d", i), 32'(rd_n), 32'(NRD[i]));
         // R3: table entry address
         if (NRD[i] == 2)
            chk(rd_a1 == PTEA[i], $sformatf("R3 tbl addr v%0d", i), rd_a1, PTEA[i]);
         // R8 R9: write-back count
         chk(wr_n == NWR[i], $sformatf("R8/R9 write count v%0d", i), 32'(wr_n), 32'(NWR[i]));
         if (NWR[i] == 1) begin
            chk(wr_a == PTEA[i], $sformatf("R8 wb addr v%0d", i), wr_a, PTEA[i]);
            chk(wr_d == WD[i], $sformatf("R8 wb data v%0d", i), wr_d, WD[i]);
         end
      end

      // R9: entry already dirty after the write-back
      chk(mrd(32'h123454a8) == 32'h14817017, "R9 entry kept", mrd(32'h123454a8), 32'h14817017);
      chk(mrd(32'h123454b4) == 32'h0000a017, "R9 dirty entry untouched",
          mrd(32'h123454b4), 32'h0000a017);

      // R2: base register change with long stalls
      lat_cfg   = 5;
      stall_cfg = 1;
      ptbr      = 32'h2000_0000;
      walk(32'h7192a44c, 2'd0, f, pa, hs_ok);
      chk(rd_a0 == 32'h20000718, "R2 new base", rd_a0, 32'h20000718);
      chk(f == 2'd1, "R5 missing dir entry", 32'(f), 32'h1);
      chk(rd_n == 1, "R5 single read", 32'(rd_n), 32'h1);

      // R11 under stalls: walk resumes correctly after changing back
      ptbr = 32'h1000_5000;
      walk(32'h7192b123, 2'd2, f, pa, hs_ok);
      chk(pa == 32'h2abcd123, "R11 stalled walk", pa, 32'h2abcd123);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule